// File: doc/BRIEF.md
# Page-Aware DRAM Command Scheduler with Refresh-Based Aging

This block holds a small set of pending DRAM read and write commands and chooses which one goes out next on a valid/ready issue channel. When no other rule applies it keeps arrival order. It prefers writes that target the page left open by the last issued command, because these are page hits. Reads and page misses wait while such writes exist, even if they arrived earlier.

Page-hit preference can starve a read. To prevent this, every pending command carries an age counter. The counter advances on a refresh tick pulse, not on the clock. Once a command's age passes a programmable 4-bit limit, it is issued ahead of all younger work, including page-hit writes. The limit covers 1 to 16 refresh intervals. With intervals of roughly 3.9 µs, the worst-case wait is held near 62 µs.

The selection is combinational over the stored queue, so a command presented on the issue port leaves the queue in the cycle its handshake completes.

Top module: `cmd_sched`

## Requirements
- R1: After reset the queue is empty: `iss_valid_o` is 0, `enq_ready_o` is 1 and no page counts as open.
- R2: The queue holds up to DEPTH (8) commands. `enq_ready_o` is 0 whenever DEPTH commands are held, including a cycle in which one of them is being issued. An enqueue offered while `enq_ready_o` is 0 is dropped.
- R3: When no command is aged out and no pending write hits the open page, the oldest pending command by arrival is presented.
- R4: When no command is aged out, the oldest pending write (`enq_is_wr_i`=1) whose page equals the open page is presented ahead of any older read or page-miss command.
- R5: After an issue handshake, the open page becomes the page of the issued command.
- R6: A pending command's age starts at 0 on enqueue. It rises by one on each cycle with `refresh_tick_i` high and saturates at 16. A command enqueued in a tick cycle starts at 0.
- R7: A `age_limit_i` value v sets a limit of v+1 refresh intervals. A command whose age is at least v+1 is aged out and is presented ahead of all commands that are not aged out, page-hit writes included.
- R8: Among several aged-out commands, the oldest by arrival is presented.
- R9: `iss_valid_o` is 1 exactly when the queue is non-empty. A presented command is removed only on a cycle with `iss_valid_o` and `iss_ready_i` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_valid_i | input | 1 | Enqueue request |
| enq_is_wr_i | input | 1 | Enqueued command is a write (1) or read (0) |
| enq_page_i | input | PAGE_W | Page of the enqueued command |
| enq_ready_o | output | 1 | Queue has a free slot |
| refresh_tick_i | input | 1 | One-cycle pulse per refresh interval |
| age_limit_i | input | AGE_W | Age limit code, limit = value + 1 intervals |
| iss_valid_o | output | 1 | A command is presented |
| iss_ready_i | input | 1 | Downstream accepts the presented command |
| iss_is_wr_o | output | 1 | Presented command is a write |
| iss_page_o | output | PAGE_W | Page of the presented command |

## Verification
The bench builds the block at its defaults: 8 entries, 8-bit pages and a 4-bit age limit. It draws pages from only four values so that page hits and misses both occur often. Most random phases use age limits of 1 to 4 intervals, so aged-out commands, the override of page-hit writes and the oldest-first rule among aged commands appear within a few ticks. A phase at the top code 15 holds the queue long enough to push ages through the saturation value of 16, and directed fills drive the queue full while issue is held off.

// File: rtl/cmd_sched_pkg.sv
package cmd_sched_pkg;
  typedef enum logic [1:0] {
    PICK_FIFO = 2'd0,
    PICK_HIT  = 2'd1,
    PICK_AGED = 2'd2
  } pick_kind_t;
endpackage

// File: rtl/cmd_sched_queue.sv
// Compacting arrival-ordered store: slot 0 is always the oldest entry.
module cmd_sched_queue #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned AGE_W  = 4,
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned AGE_CW = AGE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              push_wr_i,
  input  logic [PAGE_W-1:0] push_page_i,
  input  logic              pop_i,
  input  logic [IDX_W-1:0]  pop_idx_i,
  input  logic              tick_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              vld_o  [DEPTH],
  output logic              wr_o   [DEPTH],
  output logic [PAGE_W-1:0] page_o [DEPTH],
  output logic [AGE_CW-1:0] age_o  [DEPTH]
);
  localparam logic [AGE_CW-1:0] AGE_MAX = AGE_CW'(2 ** AGE_W);

  logic              wr_q   [DEPTH];
  logic [PAGE_W-1:0] page_q [DEPTH];
  logic [AGE_CW-1:0] age_q  [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_mid, cnt_d;

  logic              sh_wr   [DEPTH];
  logic [PAGE_W-1:0] sh_page [DEPTH];
  logic [AGE_CW-1:0] sh_age  [DEPTH];

  logic              wr_d   [DEPTH];
  logic [PAGE_W-1:0] page_d [DEPTH];
  logic [AGE_CW-1:0] age_d  [DEPTH];

  // close the gap left by the popped entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g < DEPTH - 1) begin : g_mid
      logic take_next;
      assign take_next  = pop_i && (IDX_W'(g) >= pop_idx_i);
      assign sh_wr[g]   = take_next ? wr_q[g+1]   : wr_q[g];
      assign sh_page[g] = take_next ? page_q[g+1] : page_q[g];
      assign sh_age[g]  = take_next ? age_q[g+1]  : age_q[g];
    end else begin : g_last
      assign sh_wr[g]   = wr_q[g];
      assign sh_page[g] = page_q[g];
      assign sh_age[g]  = age_q[g];
    end
  end

  always_comb begin
    cnt_mid = cnt_q - CNT_W'(pop_i);
    cnt_d   = cnt_mid + CNT_W'(push_i);
    for (int i = 0; i < DEPTH; i++) begin
      wr_d[i]   = sh_wr[i];
      page_d[i] = sh_page[i];
      age_d[i]  = (tick_i && sh_age[i] != AGE_MAX) ? sh_age[i] + 1'b1 : sh_age[i];
      if (push_i && CNT_W'(i) == cnt_mid) begin
        wr_d[i]   = push_wr_i;
        page_d[i] = push_page_i;
        age_d[i]  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        wr_q[i]   <= 1'b0;
        page_q[i] <= '0;
        age_q[i]  <= '0;
      end
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) begin
        wr_q[i]   <= wr_d[i];
        page_q[i] <= page_d[i];
        age_q[i]  <= age_d[i];
      end
    end
  end

  always_comb begin
    cnt_o = cnt_q;
    for (int i = 0; i < DEPTH; i++) begin
      vld_o[i]  = CNT_W'(i) < cnt_q;
      wr_o[i]   = wr_q[i];
      page_o[i] = page_q[i];
      age_o[i]  = age_q[i];
    end
  end
endmodule

// File: rtl/cmd_sched_pick.sv
// Priority: aged-out (oldest) > open-page write (oldest) > oldest.
module cmd_sched_pick
  import cmd_sched_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned AGE_W  = 4,
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned AGE_CW = AGE_W + 1
) (
  input  logic              vld_i  [DEPTH],
  input  logic              wr_i   [DEPTH],
  input  logic [PAGE_W-1:0] page_i [DEPTH],
  input  logic [AGE_CW-1:0] age_i  [DEPTH],
  input  logic [AGE_W-1:0]  limit_i,
  input  logic              open_vld_i,
  input  logic [PAGE_W-1:0] open_page_i,
  output logic              sel_vld_o,
  output logic [IDX_W-1:0]  sel_idx_o,
  output pick_kind_t        kind_o,
  output logic              any_aged_o,
  output logic              any_hit_o
);
  logic [DEPTH-1:0] aged, hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    assign aged[g] = vld_i[g] && (age_i[g] > {1'b0, limit_i});
    assign hit[g]  = vld_i[g] && wr_i[g] && open_vld_i && (page_i[g] == open_page_i);
  end

  logic [IDX_W-1:0] first_aged, first_hit;

  always_comb begin
    first_aged = '0;
    first_hit  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (aged[i]) first_aged = IDX_W'(i);
      if (hit[i])  first_hit  = IDX_W'(i);
    end
  end

  assign any_aged_o = |aged;
  assign any_hit_o  = |hit;
  assign sel_vld_o  = vld_i[0];

  always_comb begin
    if (any_aged_o) begin
      sel_idx_o = first_aged;
      kind_o    = PICK_AGED;
    end else if (any_hit_o) begin
      sel_idx_o = first_hit;
      kind_o    = PICK_HIT;
    end else begin
      sel_idx_o = '0;
      kind_o    = PICK_FIFO;
    end
  end
endmodule

// File: rtl/cmd_sched.sv
module cmd_sched
  import cmd_sched_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned AGE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic              enq_is_wr_i,
  input  logic [PAGE_W-1:0] enq_page_i,
  output logic              enq_ready_o,
  input  logic              refresh_tick_i,
  input  logic [AGE_W-1:0]  age_limit_i,
  output logic              iss_valid_o,
  input  logic              iss_ready_i,
  output logic              iss_is_wr_o,
  output logic [PAGE_W-1:0] iss_page_o
);
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned AGE_CW = AGE_W + 1;

  logic              q_vld  [DEPTH];
  logic              q_wr   [DEPTH];
  logic [PAGE_W-1:0] q_page [DEPTH];
  logic [AGE_CW-1:0] q_age  [DEPTH];
  logic [CNT_W-1:0]  q_cnt;

  logic              sel_vld;
  logic [IDX_W-1:0]  sel_idx;
  pick_kind_t        sel_kind;
  logic              any_aged, any_hit;

  logic              open_vld_q;
  logic [PAGE_W-1:0] open_page_q;
  logic [AGE_CW-1:0] iss_age;
  logic              push, pop;

  assign enq_ready_o = q_cnt < CNT_W'(DEPTH);
  assign push        = enq_valid_i && enq_ready_o;
  assign pop         = iss_valid_o && iss_ready_i;

  cmd_sched_queue #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .AGE_W(AGE_W)) queue_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_wr_i   (enq_is_wr_i),
    .push_page_i (enq_page_i),
    .pop_i       (pop),
    .pop_idx_i   (sel_idx),
    .tick_i      (refresh_tick_i),
    .cnt_o       (q_cnt),
    .vld_o       (q_vld),
    .wr_o        (q_wr),
    .page_o      (q_page),
    .age_o       (q_age)
  );

  cmd_sched_pick #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .AGE_W(AGE_W)) pick_i (
    .vld_i       (q_vld),
    .wr_i        (q_wr),
    .page_i      (q_page),
    .age_i       (q_age),
    .limit_i     (age_limit_i),
    .open_vld_i  (open_vld_q),
    .open_page_i (open_page_q),
    .sel_vld_o   (sel_vld),
    .sel_idx_o   (sel_idx),
    .kind_o      (sel_kind),
    .any_aged_o  (any_aged),
    .any_hit_o   (any_hit)
  );

  assign iss_valid_o = sel_vld;
  assign iss_is_wr_o = q_wr[sel_idx];
  assign iss_page_o  = q_page[sel_idx];
  assign iss_age     = q_age[sel_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_vld_q  <= 1'b0;
      open_page_q <= '0;
    end else if (pop) begin
      open_vld_q  <= 1'b1;
      open_page_q <= iss_page_o;
    end
  end
endmodule

// File: rtl/cmd_sched_chk.sv
module cmd_sched_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned AGE_W  = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned AGE_CW = AGE_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enq_valid_i,
  input logic              enq_ready_o,
  input logic              iss_valid_o,
  input logic              iss_ready_i,
  input logic              iss_is_wr_o,
  input logic [PAGE_W-1:0] iss_page_o,
  input logic [AGE_W-1:0]  age_limit_i,
  input logic [AGE_CW-1:0] iss_age_i,
  input logic              any_aged_i,
  input logic              any_hit_i,
  input logic              open_vld_i,
  input logic [PAGE_W-1:0] open_page_i
);
  logic [CNT_W:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else occ_q <= occ_q + (CNT_W+1)'(enq_valid_i && enq_ready_o)
                        - (CNT_W+1)'(iss_valid_o && iss_ready_i);
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= (CNT_W+1)'(DEPTH));

  p_valid_occ_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o == (occ_q != '0));

  p_hold_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o && !iss_ready_i |=> iss_valid_o);

  p_aged_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_aged_i |-> iss_age_i > {1'b0, age_limit_i});

  p_hit_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit_i && !any_aged_i |-> iss_is_wr_o && open_vld_i && iss_page_o == open_page_i);

  p_open_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o && iss_ready_i |=> open_vld_i && open_page_i == $past(iss_page_o));
endmodule

bind cmd_sched cmd_sched_chk #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .AGE_W(AGE_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enq_valid_i (enq_valid_i),
  .enq_ready_o (enq_ready_o),
  .iss_valid_o (iss_valid_o),
  .iss_ready_i (iss_ready_i),
  .iss_is_wr_o (iss_is_wr_o),
  .iss_page_o  (iss_page_o),
  .age_limit_i (age_limit_i),
  .iss_age_i   (iss_age),
  .any_aged_i  (any_aged),
  .any_hit_i   (any_hit),
  .open_vld_i  (open_vld_q),
  .open_page_i (open_page_q)
);

// File: tb/cmd_sched_tb_top.sv
module cmd_sched_tb_top;
  localparam int DEPTH  = 8;
  localparam int PAGE_W = 8;
  localparam int AGE_W  = 4;
  localparam int AGE_SAT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_is_wr = 1'b0, enq_ready;
  logic [PAGE_W-1:0] enq_page = '0;
  logic refresh_tick = 1'b0;
  logic [AGE_W-1:0] age_limit = '0;
  logic iss_valid, iss_ready = 1'b0, iss_is_wr;
  logic [PAGE_W-1:0] iss_page;

  always #10 clk = ~clk; // 50 MHz

  cmd_sched #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .AGE_W(AGE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_is_wr_i(enq_is_wr), .enq_page_i(enq_page),
    .enq_ready_o(enq_ready), .refresh_tick_i(refresh_tick), .age_limit_i(age_limit),
    .iss_valid_o(iss_valid), .iss_ready_i(iss_ready),
    .iss_is_wr_o(iss_is_wr), .iss_page_o(iss_page)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference model
  int m_cnt;
  bit m_wr [DEPTH];
  int m_pg [DEPTH];
  int m_age [DEPTH];
  bit m_open_v;
  int m_open;

  function automatic int m_pick(input int lim, output string tag);
    for (int i = 0; i < m_cnt; i++)
      if (m_age[i] >= lim + 1) begin tag = "R6 R7 R8"; return i; end
    if (m_open_v)
      for (int i = 0; i < m_cnt; i++)
        if (m_wr[i] && m_pg[i] == m_open) begin tag = "R4 R5"; return i; end
    tag = "R3";
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit ev, input bit ew, input int pg,
                      input bit tk, input bit rd, input int lim);
    int idx;
    string tag;
    bit pop;
    bit push;
    @(negedge clk);
    age_limit = AGE_W'(lim);
    enq_valid = ev; enq_is_wr = ew; enq_page = PAGE_W'(pg);
    refresh_tick = tk; iss_ready = rd;
    #1;
    check(enq_ready == (m_cnt < DEPTH), "R2", "enq_ready", int'(enq_ready), int'(m_cnt < DEPTH));
    check(iss_valid == (m_cnt != 0), "R9", "iss_valid", int'(iss_valid), int'(m_cnt != 0));
    idx = 0;
    tag = "R3";
    if (m_cnt != 0) begin
      idx = m_pick(lim, tag);
      check(iss_is_wr == m_wr[idx], tag, "iss_is_wr", int'(iss_is_wr), int'(m_wr[idx]));
      check(int'(iss_page) == m_pg[idx], tag, "iss_page", int'(iss_page), m_pg[idx]);
    end
    push = ev && (m_cnt < DEPTH);
    pop  = rd && (m_cnt != 0);
    if (pop) begin
      m_open_v = 1'b1;
      m_open = m_pg[idx];
      for (int i = idx; i < DEPTH - 1; i++) begin
        m_wr[i] = m_wr[i+1]; m_pg[i] = m_pg[i+1]; m_age[i] = m_age[i+1];
      end
      m_cnt--;
    end
    if (tk)
      for (int i = 0; i < m_cnt; i++)
        if (m_age[i] < AGE_SAT) m_age[i]++;
    if (push) begin
      m_wr[m_cnt] = ew; m_pg[m_cnt] = pg; m_age[m_cnt] = 0;
      m_cnt++;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lim;
    void'($urandom(32'h1357_9bdf));
    m_cnt = 0; m_open_v = 1'b0; m_open = 0;
    for (int i = 0; i < DEPTH; i++) begin m_wr[i] = 0; m_pg[i] = 0; m_age[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check(!iss_valid, "R1", "reset iss_valid", int'(iss_valid), 0);
    check(enq_ready, "R1", "reset enq_ready", int'(enq_ready), 1);
    rst_n = 1'b1;

    // R1: no open page yet, so write to page 0 does not jump an older read
    step(1, 0, 2, 0, 0, 15);
    step(1, 1, 0, 0, 0, 15);
    step(0, 0, 0, 0, 1, 15);
    step(0, 0, 0, 0, 1, 15);
    // R2: fill beyond capacity with issue held off, then push while issuing from full
    for (int i = 0; i < DEPTH + 2; i++) step(1, i[0], i, 0, 0, 15);
    step(1, 1, 9, 0, 1, 15);
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 1, 15);
    // R4 R5: open page 5, then older read/miss vs later hit write
    step(1, 1, 5, 0, 1, 15);
    step(1, 0, 1, 0, 0, 15);
    step(1, 1, 6, 0, 0, 15);
    step(1, 1, 5, 0, 0, 15);
    step(1, 1, 5, 0, 0, 15);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 15);
    // R7: limit 1 interval, aged read overrides hit write
    step(1, 1, 3, 0, 1, 0);
    step(1, 0, 7, 0, 0, 0);
    step(1, 1, 3, 1, 0, 0);
    step(1, 1, 3, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0);
    // R6 R8: saturation with the top limit code
    for (int i = 0; i < 4; i++) step(1, 1, 4, 0, 0, 15);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 0, 15);
    step(1, 1, 4, 0, 1, 15);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 15);

    // constrained random
    lim = 1;
    for (int c = 0; c < 6000; c++) begin
      if (c % 250 == 0) lim = (c % 1500 == 0) ? 15 : int'($urandom % 4);
      step(($urandom % 10) < 6, $urandom % 2, int'($urandom % 4),
           ($urandom % 8) == 0, ($urandom % 10) < 4, lim);
    end
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 1, lim);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule